// File: doc/BRIEF.md
# Compare-Match Square-Wave Generator

This block divides the input clock down to an adjustable square wave, with no software involved once it is set up. An internal prescaler makes one timer tick every four input clocks. A 16-bit timer counts those ticks and is compared against a 16-bit compare value. When the two are equal, the selected mode decides what happens: the output level flips, the timer is cleared, or both. Every match also sets a sticky match flag.

Software programs the block through a byte-wide write port. The compare value is sent as two bytes. The low byte is held aside, and the high-byte write commits both bytes at once as a staged value. The active comparator picks up the staged value only when the timer clears or wraps, so a change made while the block is running never cuts a half-period short. In idle mode the timer is held at zero and the staged value is copied across immediately, so the first period after enabling already uses the new divisor. The combined toggle-and-clear mode gives a 50% duty wave whose period is 2×(compare+1) ticks.

Top module: `fgen_top`

## Requirements
- R1: After synchronous reset, `timer_q` is 0, `wave_o` is 0, `wave_oe` is 0, `match_flag` is 0 and the mode is idle.
- R2: In any non-idle mode the timer advances by exactly one every 4 input clocks.
- R3: A write to address 0 stores the low compare byte without changing the compare value. A write to address 1 commits {written byte, held low byte} as the new 16-bit compare value.
- R4: Mode 1 (control bits [1:0] = 01, toggle) inverts the output level when the timer equals the compare value and sets the flag. The timer is not cleared and goes on to compare+1.
- R5: Mode 2 (control bits [1:0] = 10, clear) loads 0 into the timer after the tick on which it equals the compare value, and never changes the output level.
- R6: Mode 3 (control bits [1:0] = 11, toggle and clear) inverts the level and clears the timer on each match. Each half-period is compare+1 ticks (4×(compare+1) clocks), so compare 0 gives a toggle on every tick.
- R7: A compare value committed while the block runs takes effect only at the next timer clear or wrap. In idle mode (control bits [1:0] = 00) the timer is held at 0 and a committed value takes effect at once.
- R8: `match_flag` stays set until a write to address 3 with data bit 0 set. If a match and such a write fall in the same cycle, the flag stays set.
- R9: Control bit 2 enables the output. While it is 0, `wave_o` is held at 0. `wave_oe` follows this bit.
- R10: Writing a new mode, including idle, does not change the output level, and idle holds the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare low, 1 compare high, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data byte |
| wave_o | output | 1 | Generated square wave, gated by the output enable |
| wave_oe | output | 1 | Output-enable state (control bit 2) |
| match_flag | output | 1 | Sticky compare-match flag |
| timer_q | output | 16 | Current timer value |

## Verification
The assertions assume reset is held high at the first clock edge. Their checks of pin edges only look at cycles in which the output enable was the same on both sides, so that turning the enable on or off is never mistaken for a toggle. The stimulus changes the enable only through control writes made while the expected output is steady. It times every write half a clock away from the active edge. The one test that must land a flag clear on the same cycle as a match is placed by counting clocks from an observed timer step, not by reading the prescaler.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'b00,
        MODE_TOGGLE = 2'b01,
        MODE_CLEAR  = 2'b10,
        MODE_BOTH   = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ADDR_CMP_LO = 2'd0,
        ADDR_CMP_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_FLAG   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      oe;
        cmp_mode_e mode;
    } ctrl_t;

    localparam int unsigned CTRL_OE_BIT  = 2;
    localparam int unsigned FLAG_CLR_BIT = 0;

    function automatic logic mode_toggles(input cmp_mode_e m);
        return (m == MODE_TOGGLE) || (m == MODE_BOTH);
    endfunction

    function automatic logic mode_clears(input cmp_mode_e m);
        return (m == MODE_CLEAR) || (m == MODE_BOTH);
    endfunction

    function automatic logic mode_running(input cmp_mode_e m);
        return m != MODE_IDLE;
    endfunction

endpackage

// File: rtl/fgen_tick.sv
module fgen_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/fgen_regs.sv
module fgen_regs
    import fgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             match,
    output logic [CNT_W-1:0] cmp_stage,
    output ctrl_t            ctrl,
    output logic             flag
);
    localparam int unsigned LO_W = CNT_W - BUS_W;

    reg_addr_e      sel;
    logic           flag_clr;
    logic [LO_W-1:0] lo_hold;

    assign sel      = reg_addr_e'(wr_addr);
    assign flag_clr = wr_en && (sel == ADDR_FLAG) && wr_data[FLAG_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold   <= '0;
            cmp_stage <= '1;
            ctrl      <= '{oe: 1'b0, mode: MODE_IDLE};
        end else if (wr_en) begin
            unique case (sel)
                ADDR_CMP_LO: lo_hold   <= wr_data[LO_W-1:0];
                ADDR_CMP_HI: cmp_stage <= {wr_data, lo_hold};
                ADDR_CTRL: begin
                    ctrl.oe   <= wr_data[CTRL_OE_BIT];
                    ctrl.mode <= cmp_mode_e'(wr_data[1:0]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= match | (flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/fgen_core.sv
module fgen_core
    import fgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cmp_mode_e        mode,
    input  logic [CNT_W-1:0] cmp_stage,
    output logic [CNT_W-1:0] timer,
    output logic             level,
    output logic             match
);
    logic [CNT_W-1:0] cmp_act;
    logic             step;
    logic             clr_now;
    logic             wrap_now;

    always_comb begin
        step     = tick && mode_running(mode);
        match    = step && (timer == cmp_act);
        clr_now  = match && mode_clears(mode);
        wrap_now = step && (timer == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer   <= '0;
            cmp_act <= '1;
            level   <= 1'b0;
        end else if (!mode_running(mode)) begin
            timer   <= '0;
            cmp_act <= cmp_stage;
        end else if (step) begin
            timer <= clr_now ? '0 : timer + 1'b1;
            if (clr_now || wrap_now) begin
                cmp_act <= cmp_stage;
            end
            if (match && mode_toggles(mode)) begin
                level <= ~level;
            end
        end
    end
endmodule

// File: rtl/fgen_top.sv
module fgen_top
    import fgen_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic             wave_o,
    output logic             wave_oe,
    output logic             match_flag,
    output logic [CNT_W-1:0] timer_q
);
    logic             tick;
    logic             match;
    logic             level;
    logic [CNT_W-1:0] cmp_stage;
    ctrl_t            ctrl_q;
    cmp_mode_e        cfg_mode;

    assign cfg_mode = ctrl_q.mode;

    fgen_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fgen_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .match     (match),
        .cmp_stage (cmp_stage),
        .ctrl      (ctrl_q),
        .flag      (match_flag)
    );

    fgen_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (cfg_mode),
        .cmp_stage (cmp_stage),
        .timer     (timer_q),
        .level     (level),
        .match     (match)
    );

    assign wave_oe = ctrl_q.oe;
    assign wave_o  = ctrl_q.oe & level;
endmodule

// File: rtl/fgen_checker.sv
module fgen_checker
    import fgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [BUS_W-1:0] wr_data,
    input logic             wave_o,
    input logic             wave_oe,
    input logic             match_flag,
    input logic [CNT_W-1:0] timer_q,
    input cmp_mode_e        mode
);
    logic flag_wr1;
    assign flag_wr1 = wr_en && (wr_addr == 2'd3) && wr_data[0];

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> (timer_q == '0) && !wave_o && !wave_oe && !match_flag);

    p_timer_step_r2: assert property (@(posedge clk) disable iff (rst)
        (timer_q != $past(timer_q)) |-> ((timer_q == $past(timer_q) + 1'b1) || (timer_q == '0)));

    p_edge_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (wave_oe && $past(wave_oe) && (wave_o != $past(wave_o))) |-> match_flag);

    p_clear_still_r5: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_CLEAR) && ($past(mode) == MODE_CLEAR) && wave_oe && $past(wave_oe))
        |-> (wave_o == $past(wave_o)));

    p_both_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) == MODE_BOTH) && wave_oe && $past(wave_oe) && (wave_o != $past(wave_o)))
        |-> (timer_q == '0));

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_wr1) |=> match_flag);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE) |=> (timer_q == '0));

    p_gate_low_r9: assert property (@(posedge clk) disable iff (rst)
        !wave_oe |-> !wave_o);
endmodule

bind fgen_top fgen_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wave_o     (wave_o),
    .wave_oe    (wave_oe),
    .match_flag (match_flag),
    .timer_q    (timer_q),
    .mode       (cfg_mode)
);

// File: tb/sim_fgen_top.sv
`timescale 1ns/1ps
module sim_fgen_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        wave_o;
    logic        wave_oe;
    logic        match_flag;
    logic [15:0] timer_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    fgen_top u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wave_o     (wave_o),
        .wave_oe    (wave_oe),
        .match_flag (match_flag),
        .timer_q    (timer_q)
    );

    always #2.5 clk = ~clk;

    // compare value and expected half-period in input clocks (mode 3)
    localparam logic [15:0] VEC_CMP [0:5] = '{16'd0, 16'd1, 16'd2, 16'd5, 16'd9, 16'd40};
    localparam int          VEC_EXP [0:5] = '{4, 8, 12, 24, 40, 164};

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; write is taken at the next posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic wait_edge(output int c, input int limit);
        logic p;
        p = wave_o;
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (wave_o == p && c < limit);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        logic lv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 timer", timer_q, 0);
        chk("R1 wave", wave_o, 0);
        chk("R1 oe", wave_oe, 0);
        chk("R1 flag", match_flag, 0);

        // R6 table walk: toggle-and-clear half periods
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, 8'h00);
            set_cmp(VEC_CMP[i]);
            wr(2'd2, 8'h07);
            wait_edge(c, 400);
            chk("R6 timer cleared at toggle", timer_q, 0);
            for (int k = 0; k < 2; k++) begin
                wait_edge(c, 400);
                chk("R6 half period", c, VEC_EXP[i]);
            end
        end

        // R2 tick spacing in clear mode
        wr(2'd2, 8'h00);
        set_cmp(16'd100);
        wr(2'd2, 8'h06);
        begin
            logic [15:0] p;
            p = timer_q;
            c = 0;
            while (timer_q == p && c < 20) begin @(negedge clk); c++; end
            p = timer_q;
            c = 0;
            while (timer_q == p && c < 20) begin @(negedge clk); c++; end
            chk("R2 clocks per tick", c, 4);
            chk("R2 step of one", int'(timer_q) - int'(p), 1);
        end

        // R5 clear mode: timer wraps after compare, no pin edge
        wr(2'd2, 8'h00);
        set_cmp(16'd4);
        wr(2'd2, 8'h06);
        begin
            int mx, edges, wraps;
            logic pw;
            logic [15:0] pt;
            mx = 0; edges = 0; wraps = 0;
            pw = wave_o; pt = timer_q;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (int'(timer_q) > mx) mx = int'(timer_q);
                if (wave_o != pw) edges++;
                if (pt == 16'd4 && timer_q == 16'd0) wraps++;
                pw = wave_o; pt = timer_q;
            end
            chk("R5 highest timer value", mx, 4);
            chk("R5 pin edges", edges, 0);
            chk("R5 cleared after compare", int'(wraps > 0), 1);
        end

        // R4 toggle mode: pin flips, timer keeps counting
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        chk("R8 flag cleared by write", match_flag, 0);
        set_cmp(16'd5);
        wr(2'd2, 8'h05);
        wait_edge(c, 200);
        chk("R4 timer after toggle", timer_q, 6);
        chk("R4 flag set", match_flag, 1);
        wait_edge(c, 200);
        chk("R4 no second edge before wrap", c, 200);
        chk("R4 timer not cleared", timer_q, 56);
        chk("R8 flag still held", match_flag, 1);

        // R7 compare change mid-period applies at next clear
        wr(2'd2, 8'h00);
        set_cmp(16'd3);
        wr(2'd2, 8'h07);
        wait_edge(c, 200);
        set_cmp(16'd1);
        wait_edge(c, 200);
        chk("R7 old compare finishes period", c + 2, 16);
        wait_edge(c, 200);
        chk("R7 new compare after clear", c, 8);

        // R3 low byte alone does not change the compare
        wr(2'd2, 8'h00);
        set_cmp(16'd2);
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h07);
        wait_edge(c, 300);
        wait_edge(c, 300);
        chk("R3 low byte held only", c, 12);
        wr(2'd1, 8'd0);
        wait_edge(c, 300);
        wait_edge(c, 300);
        chk("R3 high byte commits pair", c, 32);

        // R9 output enable gating
        wr(2'd2, 8'h00);
        set_cmp(16'd0);
        wr(2'd2, 8'h03);
        chk("R9 oe low", wave_oe, 0);
        begin
            int ones;
            ones = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (wave_o) ones++;
            end
            chk("R9 pin held low", ones, 0);
        end
        wr(2'd2, 8'h07);
        chk("R9 oe high", wave_oe, 1);
        begin
            int edges;
            logic pw;
            edges = 0;
            pw = wave_o;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (wave_o != pw) edges++;
                pw = wave_o;
            end
            chk("R9 edges when enabled", edges, 10);
        end

        // R10 mode writes keep the level
        wr(2'd2, 8'h00);
        set_cmp(16'd9);
        wr(2'd2, 8'h07);
        wait_edge(c, 200);
        lv = wave_o;
        wr(2'd2, 8'h04);
        chk("R10 level after idle write", wave_o, lv);
        repeat (60) @(negedge clk);
        chk("R10 idle holds level", wave_o, lv);
        wr(2'd2, 8'h06);
        repeat (60) @(negedge clk);
        chk("R10 level after clear-mode write", wave_o, lv);

        // R8 clear on the same cycle as a match
        wr(2'd2, 8'h00);
        set_cmp(16'd3);
        wr(2'd2, 8'h06);
        begin
            logic [15:0] p;
            p = timer_q;
            c = 0;
            do begin
                p = timer_q;
                @(negedge clk);
                c++;
            end while (!(timer_q == 16'd3 && p == 16'd2) && c < 100);
        end
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h01);
        chk("R8 match cycle reached", timer_q, 0);
        chk("R8 set wins over clear", match_flag, 1);
        wr(2'd3, 8'h01);
        chk("R8 clear without match", match_flag, 0);
        repeat (20) @(negedge clk);
        chk("R8 set again by match", match_flag, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule